// File: doc/BRIEF.md
# Condition Flag Store and Branch Resolver

This block keeps the four arithmetic condition flags (negative, zero, carry, overflow) in a small register. It also decides whether the control-transfer instruction now being resolved is taken. The flag register loads the ALU's flag bus on a rising clock edge, but only in a cycle where the set-flags strobe is high. Otherwise it keeps its contents for as long as needed.

The resolver is combinational and gives a single `taken` bit. Its inputs are:
- a 3-bit branch kind;
- a 4-bit condition selector;
- a 64-bit register operand;
- the flags held in the register.

Flag-based decisions use the stored flags only. A flag update requested in the same cycle affects decisions from the next cycle on.

Inside the block, a small control decoder turns the branch kind into a struct of strobes. A datapath module holds the flags, evaluates every condition in parallel and combines the strobes with those results.

Top module: `cond_branch_unit`

## Requirements
- R1: A synchronous active-high `rst` clears all four stored flags to zero. After reset, condition 1 (not equal) is taken and conditions 0, 2, 4 and 6 are not taken.
- R2: On a rising edge with `setFlags` high, the stored flags load `aluFlags`, with the bits laid out as N=bit 3, Z=bit 2, C=bit 1, V=bit 0. Decisions from the next cycle on use the new values.
- R3: While `setFlags` is low, the stored flags keep their value over any number of cycles, whatever `aluFlags` carries.
- R4: In the cycle in which `aluFlags` is offered for loading, a flag-based decision still uses the previously stored flags.
- R5: Branch kind 0 (none) and the unused kind 7 never assert `taken`.
- R6: Branch kinds 1 (plain branch), 2 (branch and link) and 3 (branch to register) always assert `taken`.
- R7: Kind 4 (compare and branch if zero) is taken exactly when `regValue` is zero. Kind 5 (compare and branch if nonzero) is taken exactly when `regValue` is not zero.
- R8: For kind 6 (flag branch), the single-flag conditions give `taken` as follows:
  - 0 = Z
  - 1 = !Z
  - 2 = C
  - 3 = !C
  - 4 = N
  - 5 = !N
  - 6 = V
  - 7 = !V
- R9: For kind 6, the compound conditions give `taken` as follows:
  - 8 = C&!Z
  - 9 = !C|Z
  - 10 = (N==V)
  - 11 = (N!=V)
  - 12 = !Z&(N==V)
  - 13 = Z|(N!=V)
- R10: For kind 6, condition selectors 14 and 15 are never taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the flags |
| setFlags | input | 1 | Load strobe for the flag register |
| aluFlags | input | 4 | Flag bus from the ALU, {N,Z,C,V} |
| brType | input | 3 | Branch kind code |
| condCode | input | 4 | Condition selector for flag branches |
| regValue | input | 64 | Register operand for the zero/nonzero tests |
| taken | output | 1 | Branch taken decision |

## Verification
The assertions assume that `rst` is held high at the first clock edge, and that `setFlags`, `aluFlags`, `brType` and `regValue` are stable and known around each rising edge. The bench meets this by changing inputs only at the falling edge and by holding reset through the first edges. The random stimulus covers all eight branch kinds and all sixteen selectors, including the unused ones. It makes `regValue` zero about a quarter of the time so that both compare outcomes occur often.

// File: rtl/cbu_pkg.sv
package cbu_pkg;
  localparam int FLAG_W = 4;
  localparam int FN = 3;
  localparam int FZ = 2;
  localparam int FC = 1;
  localparam int FV = 0;
  localparam int COND_W = 4;
  localparam int COND_N = 1 << COND_W;

  typedef enum logic [2:0] {
    BR_NONE      = 3'd0,
    BR_ALWAYS    = 3'd1,
    BR_LINK      = 3'd2,
    BR_TOREG     = 3'd3,
    BR_IFZERO    = 3'd4,
    BR_IFNONZERO = 3'd5,
    BR_ONFLAGS   = 3'd6,
    BR_RSVD      = 3'd7
  } brKind_e;

  typedef struct packed {
    logic              takeAll;
    logic              onZero;
    logic              onNonzero;
    logic              onFlags;
    logic [COND_W-1:0] cond;
  } brStrobe_t;

  function automatic logic condHolds(input logic [COND_W-1:0] code,
                                     input logic [FLAG_W-1:0] f);
    logic nEqV;
    nEqV = f[FN] ^ f[FV];
    case (code)
      4'd0:    condHolds = f[FZ];
      4'd1:    condHolds = !f[FZ];
      4'd2:    condHolds = f[FC];
      4'd3:    condHolds = !f[FC];
      4'd4:    condHolds = f[FN];
      4'd5:    condHolds = !f[FN];
      4'd6:    condHolds = f[FV];
      4'd7:    condHolds = !f[FV];
      4'd8:    condHolds = f[FC] && !f[FZ];
      4'd9:    condHolds = !f[FC] || f[FZ];
      4'd10:   condHolds = !nEqV;
      4'd11:   condHolds = nEqV;
      4'd12:   condHolds = !f[FZ] && !nEqV;
      4'd13:   condHolds = f[FZ] || nEqV;
      default: condHolds = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/cbu_ctrl.sv
module cbu_ctrl
  import cbu_pkg::*;
(
  input  logic [2:0]        brType,
  input  logic [COND_W-1:0] condCode,
  output brStrobe_t         strobe
);
  brKind_e kind;
  assign kind = brKind_e'(brType);

  always_comb begin
    strobe = '0;
    strobe.cond = condCode;
    case (kind)
      BR_ALWAYS, BR_LINK, BR_TOREG: strobe.takeAll = 1'b1;
      BR_IFZERO:                    strobe.onZero = 1'b1;
      BR_IFNONZERO:                 strobe.onNonzero = 1'b1;
      BR_ONFLAGS:                   strobe.onFlags = 1'b1;
      default:                      strobe.cond = condCode;
    endcase
  end
endmodule

// File: rtl/cbu_dp.sv
module cbu_dp
  import cbu_pkg::*;
#(
  parameter int REG_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              setFlags,
  input  logic [FLAG_W-1:0] aluFlags,
  input  logic [REG_W-1:0]  regValue,
  input  brStrobe_t         strobe,
  output logic              taken
);
  logic [FLAG_W-1:0] flagQ;
  logic [COND_N-1:0] condVec;
  logic              isZero;

  always_ff @(posedge clk) begin
    if (rst)           flagQ <= '0;
    else if (setFlags) flagQ <= aluFlags;
  end

  for (genvar i = 0; i < COND_N; i++) begin : g_cond
    assign condVec[i] = condHolds(COND_W'(i), flagQ);
  end

  assign isZero = ~|regValue;

  assign taken = strobe.takeAll
               | (strobe.onZero & isZero)
               | (strobe.onNonzero & !isZero)
               | (strobe.onFlags & condVec[strobe.cond]);

  // R1
  flag_reset_chk: assert property (@(posedge clk) rst |=> flagQ == '0);
  // R2
  flag_load_chk: assert property (@(posedge clk) disable iff (rst)
    setFlags |=> flagQ == $past(aluFlags));
  // R3
  flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !setFlags |=> $stable(flagQ));
  // R6
  always_taken_chk: assert property (@(posedge clk) disable iff (rst)
    strobe.takeAll |-> taken);
  // R5
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strobe.takeAll, strobe.onZero, strobe.onNonzero, strobe.onFlags}));
endmodule

// File: rtl/cond_branch_unit.sv
module cond_branch_unit
  import cbu_pkg::*;
#(
  parameter int REG_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              setFlags,
  input  logic [FLAG_W-1:0] aluFlags,
  input  logic [2:0]        brType,
  input  logic [COND_W-1:0] condCode,
  input  logic [REG_W-1:0]  regValue,
  output logic              taken
);
  brStrobe_t strobe;

  cbu_ctrl ctrl_i (
    .brType(brType), .condCode(condCode), .strobe(strobe)
  );

  cbu_dp #(.REG_W(REG_W)) dp_i (
    .clk(clk), .rst(rst), .setFlags(setFlags), .aluFlags(aluFlags),
    .regValue(regValue), .strobe(strobe), .taken(taken)
  );

  // R5
  none_kind_chk: assert property (@(posedge clk) disable iff (rst)
    (brType == 3'd0 || brType == 3'd7) |-> !taken);
  // R7
  cbz_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    (brType == 3'd4 && regValue != '0) |-> !taken);
  // R7
  cbnz_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (brType == 3'd5 && regValue == '0) |-> !taken);
  // R10
  cond_unused_chk: assert property (@(posedge clk) disable iff (rst)
    (brType == 3'd6 && condCode >= 4'd14) |-> !taken);
endmodule

// File: tb/cond_branch_unit_tb_top.sv
module cond_branch_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        setFlags = 1'b0;
  logic [3:0]  aluFlags = '0;
  logic [2:0]  brType = '0;
  logic [3:0]  condCode = '0;
  logic [63:0] regValue = '0;
  logic        taken;

  int checks = 0;
  int errors = 0;
  logic [3:0] model = '0;   // bench copy of the stored flags {N,Z,C,V}

  always #2 clk = ~clk;     // 250 MHz

  cond_branch_unit dut_i (
    .clk(clk), .rst(rst), .setFlags(setFlags), .aluFlags(aluFlags),
    .brType(brType), .condCode(condCode), .regValue(regValue), .taken(taken)
  );

  function automatic logic expTaken(input logic [2:0] bt, input logic [3:0] cc,
                                    input logic [3:0] f, input logic [63:0] r);
    logic n, z, c, v;
    {n, z, c, v} = f;
    if (bt == 3'd1 || bt == 3'd2 || bt == 3'd3) return 1'b1;
    if (bt == 3'd4) return r == 64'd0;
    if (bt == 3'd5) return r != 64'd0;
    if (bt != 3'd6) return 1'b0;
    case (cc)
      4'd0: return z;
      4'd1: return !z;
      4'd2: return c;
      4'd3: return !c;
      4'd4: return n;
      4'd5: return !n;
      4'd6: return v;
      4'd7: return !v;
      4'd8: return c && !z;
      4'd9: return !c || z;
      4'd10: return n == v;
      4'd11: return n != v;
      4'd12: return !z && (n == v);
      4'd13: return z || (n != v);
      default: return 1'b0;
    endcase
  endfunction

  function automatic string tagOf(input logic [2:0] bt, input logic [3:0] cc);
    if (bt == 3'd0 || bt == 3'd7) return "R5";
    if (bt <= 3'd3) return "R6";
    if (bt <= 3'd5) return "R7";
    if (cc <= 4'd7) return "R8";
    if (cc <= 4'd13) return "R9";
    return "R10";
  endfunction

  task automatic check(input string req, input logic exp);
    checks++;
    if (taken !== exp) begin
      errors++;
      $display("FAIL %s: taken=%b expected=%b (kind=%0d cond=%0d flags=%b)",
               req, taken, exp, brType, condCode, model);
    end
  endtask

  task automatic probe(input string req, input logic [3:0] cc);
    brType = 3'd6; condCode = cc; #1;
    check(req, expTaken(3'd6, cc, model, regValue));
  endtask

  task automatic edgeStep;
    @(posedge clk);
    if (rst) model = '0;
    else if (setFlags) model = aluFlags;
    @(negedge clk);
  endtask

  initial begin : watchdog
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    aluFlags = 4'b1111;
    setFlags = 1'b1;
    @(negedge clk); edgeStep(); edgeStep();
    rst = 1'b0; setFlags = 1'b0;
    // R1: all flags cleared after reset
    probe("R1", 4'd0); probe("R1", 4'd1); probe("R1", 4'd2);
    probe("R1", 4'd4); probe("R1", 4'd6);

    // R4: offered flags not visible in the same cycle
    aluFlags = 4'b0100; setFlags = 1'b1;
    probe("R4", 4'd0);
    edgeStep();
    setFlags = 1'b0;
    // R2: visible after the edge
    probe("R2", 4'd0);
    aluFlags = 4'b1010; setFlags = 1'b1;
    edgeStep(); setFlags = 1'b0;
    probe("R2", 4'd4); probe("R2", 4'd2); probe("R2", 4'd6);

    // R3: hold over several cycles while aluFlags changes
    for (int k = 0; k < 6; k++) begin
      aluFlags = 4'(k * 5 + 1);
      edgeStep();
      probe("R3", 4'd4); probe("R3", 4'd0); probe("R3", 4'd2); probe("R3", 4'd6);
    end

    // R10: unused selectors with every flag pattern
    for (int f = 0; f < 16; f++) begin
      aluFlags = 4'(f); setFlags = 1'b1; edgeStep(); setFlags = 1'b0;
      probe("R10", 4'd14); probe("R10", 4'd15);
      for (int cc = 0; cc < 14; cc++) probe(cc < 8 ? "R8" : "R9", 4'(cc));
    end

    // R7 boundaries
    brType = 3'd4; regValue = 64'd0; #1; check("R7", 1'b1);
    regValue = 64'h8000_0000_0000_0000; #1; check("R7", 1'b0);
    brType = 3'd5; #1; check("R7", 1'b1);
    regValue = 64'd0; #1; check("R7", 1'b0);

    // Random mix
    void'($urandom(32'h5eed_cafe));
    for (int it = 0; it < 2000; it++) begin
      brType = 3'($urandom_range(0, 7));
      condCode = 4'($urandom_range(0, 15));
      aluFlags = 4'($urandom_range(0, 15));
      setFlags = 1'($urandom_range(0, 1));
      regValue = ($urandom_range(0, 3) == 0) ? 64'd0 : {$urandom, $urandom};
      #1;
      check(tagOf(brType, condCode), expTaken(brType, condCode, model, regValue));
      edgeStep();
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule